// File: doc/BRIEF.md
# Host Port Service Request Generator

This block sits between a host processor bus and a DSP core. It holds two single-word data registers. The first carries data from the host to the core, and a receive-full flag tracks it. The second carries data from the core to the host, and a transmit-full flag tracks it. The host reads a two-bit status word to poll these flags. The core moves data with plain read and write strobes, which may come from its DMA engine. No DMA signal ever reaches the host side.

The flags drive two sets of requests. Host service requests go out on one shared line or on two separate lines, chosen by a host control bit. They are asserted only when the host has enabled the direction and the core has enabled host requests. Core-side DMA requests are level signals. A five-bit source code names the pending condition.

While the core is in stop mode, the host side is cut off. All host request lines drop, and host strobes have no effect. The core side keeps working.

Top module: `host_svc_req_gen`

## Requirements
- R1: After reset all control bits are clear, both data registers read zero and are not full, and every request output is 0; `host_status` reads 2'b10.
- R2: A host data write (outside stop mode) loads the host-to-core register and sets the receive-full flag. A core read clears the flag. A write in the same cycle as a read wins. `core_dat_rdata` shows the stored word.
- R3: A core data write loads the core-to-host register and sets the transmit-full flag. A host read (outside stop mode) clears the flag. A write in the same cycle as a read wins. `host_dat_rdata` shows the stored word. `host_status` bit 0 is the transmit-full flag and bit 1 is the inverse of the receive-full flag.
- R4: A host control write stores three bits. Bit 0 enables receive requests (host can read). Bit 1 enables transmit requests (host can write). Bit 2 selects two-line mode when set and one-line mode when clear.
- R5: A core control write stores `core_pcr_wdata` bits 6:4. Bit 4 enables host requests. Bit 5 enables the receive DMA request. Bit 6 enables the transmit DMA request. While bit 4 is clear, no host request line asserts.
- R6: In one-line mode, `hreq_any` is asserted when either term holds: transmit enable with receive-full clear, or receive enable with transmit-full set. `hreq_tx` and `hreq_rx` stay 0 in this mode.
- R7: In two-line mode, `hreq_tx` carries the transmit term and `hreq_rx` carries the receive term. `hreq_any` stays 0 in this mode.
- R8: Every request output is registered. It reflects the flags and control bits as they stood before the clock edge that updates it.
- R9: `dma_rx_req` is the receive DMA enable AND receive-full. `dma_tx_req` is the transmit DMA enable AND NOT transmit-full. Neither depends on host enables or stop mode.
- R10: `dma_src` is 5'b10011 while a receive DMA request is due, otherwise 5'b10100 while a transmit DMA request is due, otherwise 5'b00000.
- R11: While `stop_mode` is high, all host request lines are 0. Host control writes, host data writes and host data reads change nothing. Core accesses still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_mode | input | 1 | Core is in stop mode; host side cut off |
| host_ctl_we | input | 1 | Host control register write strobe |
| host_ctl_wdata | input | 3 | Host control bits: receive enable, transmit enable, two-line mode |
| host_dat_we | input | 1 | Host writes the host-to-core register |
| host_dat_wdata | input | DW | Host write data |
| host_dat_re | input | 1 | Host reads the core-to-host register |
| host_dat_rdata | output | DW | Core-to-host register contents |
| host_status | output | 2 | Polled status: bit 0 data ready, bit 1 room to write |
| core_pcr_we | input | 1 | Core port control write strobe |
| core_pcr_wdata | input | 3 | Core control bits 6:4 |
| core_dat_we | input | 1 | Core writes the core-to-host register |
| core_dat_wdata | input | DW | Core write data |
| core_dat_re | input | 1 | Core reads the host-to-core register |
| core_dat_rdata | output | DW | Host-to-core register contents |
| hreq_any | output | 1 | Shared host request (one-line mode) |
| hreq_tx | output | 1 | Host transmit request (two-line mode) |
| hreq_rx | output | 1 | Host receive request (two-line mode) |
| dma_rx_req | output | 1 | Core DMA request: receive data full |
| dma_tx_req | output | 1 | Core DMA request: transmit data empty |
| dma_src | output | 5 | Source code of the highest-priority DMA request |

## Verification
A data strobe or control write changes the flags, data registers, read data and status one clock edge after it is sampled. The request lines and DMA outputs that follow from a data strobe change one edge later still, two edges after the strobe. A control-bit change or a stop-mode change moves the requests after a single edge. The bench keeps a behavioural model that advances at every rising edge and computes outputs from the state it held before that edge. The bench drives stimulus and compares every output on the falling edge, so each check lands in the cycle where the result is due.

// File: rtl/hp_pkg.sv
// Shared types and constants for the host port service request generator.
// Assumes one host control word and one core control word of a few bits each.
package hp_pkg;
    localparam logic [4:0] DMA_SRC_RXF  = 5'b10011;
    localparam logic [4:0] DMA_SRC_TXE  = 5'b10100;
    localparam logic [4:0] DMA_SRC_NONE = 5'b00000;
    localparam int         NCH          = 2;   // channel 0: host->core, 1: core->host

    typedef struct packed {
        logic split;   // bit 2: two-line mode
        logic txen;    // bit 1: transmit request enable
        logic rxen;    // bit 0: receive request enable
    } host_ctl_t;

    typedef struct packed {
        logic txdma;   // bit 6
        logic rxdma;   // bit 5
        logic hren;    // bit 4: core-side host request enable
    } core_ctl_t;
endpackage

// File: rtl/hp_ctl_regs.sv
// Control registers for both sides of the port.
// Assumes host writes are already qualified by the caller except for stop mode,
// which is applied here so a stopped core ignores host control writes.
module hp_ctl_regs
    import hp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_mode,
    input  logic      host_ctl_we,
    input  logic [2:0] host_ctl_wdata,
    input  logic      core_pcr_we,
    input  logic [6:4] core_pcr_wdata,
    output host_ctl_t hctl,
    output core_ctl_t cctl
);
    // Host control word: written only while the host side is connected.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hctl <= '0;
        else if (host_ctl_we && !stop_mode)
            hctl <= host_ctl_t'(host_ctl_wdata);
    end

    // Core control word: the core side is never cut off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cctl <= '0;
        else if (core_pcr_we)
            cctl <= core_ctl_t'(core_pcr_wdata);
    end

    // R11
    stop_ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |=> $stable(hctl));
endmodule

// File: rtl/hp_data_path.sv
// Two single-word data registers with full flags.
// Channel 0 is written by the host and read by the core; channel 1 the reverse.
// Assumes strobes arrive pre-qualified; a write in the same cycle as a read wins.
module hp_data_path
    import hp_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NCH-1:0] wr,
    input  logic [NCH-1:0] rd,
    input  logic [DW-1:0] wd [NCH],
    output logic [NCH-1:0] full,
    output logic [DW-1:0] rdat [NCH]
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic          f;
        logic [DW-1:0] d;

        // Hold one word and its full flag; a write overrides a same-cycle read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                f <= 1'b0;
                d <= '0;
            end else if (wr[ch]) begin
                f <= 1'b1;
                d <= wd[ch];
            end else if (rd[ch]) begin
                f <= 1'b0;
            end
        end

        assign full[ch] = f;
        assign rdat[ch] = d;

        // R2
        wr_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr[ch] |=> full[ch] && rdat[ch] == $past(wd[ch]));
        // R3
        rd_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd[ch] && !wr[ch]) |=> !full[ch]);
    end
endmodule

// File: rtl/hp_req_steer.sv
// Registered request generation: host request gating and steering to one
// or two lines, plus core-side DMA requests with a priority source code.
// Assumes flags and control bits come straight from registers.
module hp_req_steer
    import hp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_mode,
    input  host_ctl_t hctl,
    input  core_ctl_t cctl,
    input  logic      rx_full,
    input  logic      tx_full,
    output logic      hreq_any,
    output logic      hreq_tx,
    output logic      hreq_rx,
    output logic      dma_rx_req,
    output logic      dma_tx_req,
    output logic [4:0] dma_src
);
    logic gate, t_term, r_term, d_rx, d_tx;

    // Compute the gated request terms from the current flags and enables.
    always_comb begin
        gate   = cctl.hren && !stop_mode;
        t_term = gate && hctl.txen && !rx_full;
        r_term = gate && hctl.rxen && tx_full;
        d_rx   = cctl.rxdma && rx_full;
        d_tx   = cctl.txdma && !tx_full;
    end

    // Register the host lines, steered by the mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hreq_any <= 1'b0;
            hreq_tx  <= 1'b0;
            hreq_rx  <= 1'b0;
        end else begin
            hreq_any <= !hctl.split && (t_term || r_term);
            hreq_tx  <= hctl.split && t_term;
            hreq_rx  <= hctl.split && r_term;
        end
    end

    // Register the DMA requests and the prioritised source code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_rx_req <= 1'b0;
            dma_tx_req <= 1'b0;
            dma_src    <= DMA_SRC_NONE;
        end else begin
            dma_rx_req <= d_rx;
            dma_tx_req <= d_tx;
            dma_src    <= d_rx ? DMA_SRC_RXF : (d_tx ? DMA_SRC_TXE : DMA_SRC_NONE);
        end
    end

    // R5
    hren_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cctl.hren |=> !(hreq_any || hreq_tx || hreq_rx));
    // R6
    one_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hctl.split |=> !hreq_tx && !hreq_rx);
    // R7
    two_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hctl.split |=> !hreq_any);
    // R11
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |=> !(hreq_any || hreq_tx || hreq_rx));
    // R10
    src_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rx_req |-> dma_src == DMA_SRC_RXF) and
        ((!dma_rx_req && dma_tx_req) |-> dma_src == DMA_SRC_TXE) and
        ((!dma_rx_req && !dma_tx_req) |-> dma_src == DMA_SRC_NONE));
endmodule

// File: rtl/host_svc_req_gen.sv
// Top of the host port service request generator.
// Gates host-side strobes with stop mode and wires the control registers,
// data path and request steering together. Assumes one access per strobe.
module host_svc_req_gen
    import hp_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stop_mode,
    input  logic          host_ctl_we,
    input  logic [2:0]    host_ctl_wdata,
    input  logic          host_dat_we,
    input  logic [DW-1:0] host_dat_wdata,
    input  logic          host_dat_re,
    output logic [DW-1:0] host_dat_rdata,
    output logic [1:0]    host_status,
    input  logic          core_pcr_we,
    input  logic [6:4]    core_pcr_wdata,
    input  logic          core_dat_we,
    input  logic [DW-1:0] core_dat_wdata,
    input  logic          core_dat_re,
    output logic [DW-1:0] core_dat_rdata,
    output logic          hreq_any,
    output logic          hreq_tx,
    output logic          hreq_rx,
    output logic          dma_rx_req,
    output logic          dma_tx_req,
    output logic [4:0]    dma_src
);
    localparam int CH_H2C = 0;
    localparam int CH_C2H = 1;

    host_ctl_t      hctl;
    core_ctl_t      cctl;
    logic [NCH-1:0] wr, rd, full;
    logic [DW-1:0]  wd [NCH];
    logic [DW-1:0]  rdat [NCH];

    // Qualify the strobes: host ones are dropped during stop mode.
    always_comb begin
        wr[CH_H2C] = host_dat_we && !stop_mode;
        rd[CH_H2C] = core_dat_re;
        wr[CH_C2H] = core_dat_we;
        rd[CH_C2H] = host_dat_re && !stop_mode;
        wd[CH_H2C] = host_dat_wdata;
        wd[CH_C2H] = core_dat_wdata;
    end

    hp_ctl_regs u_ctl (
        .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode),
        .host_ctl_we(host_ctl_we), .host_ctl_wdata(host_ctl_wdata),
        .core_pcr_we(core_pcr_we), .core_pcr_wdata(core_pcr_wdata),
        .hctl(hctl), .cctl(cctl)
    );

    hp_data_path #(.DW(DW)) u_dat (
        .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .wd(wd),
        .full(full), .rdat(rdat)
    );

    hp_req_steer u_req (
        .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode),
        .hctl(hctl), .cctl(cctl),
        .rx_full(full[CH_H2C]), .tx_full(full[CH_C2H]),
        .hreq_any(hreq_any), .hreq_tx(hreq_tx), .hreq_rx(hreq_rx),
        .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req), .dma_src(dma_src)
    );

    assign host_dat_rdata = rdat[CH_C2H];
    assign core_dat_rdata = rdat[CH_H2C];
    assign host_status    = {!full[CH_H2C], full[CH_C2H]};

    // R11
    stop_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && host_dat_we && !core_dat_re) |=> $stable(core_dat_rdata));
endmodule

// File: tb/tb_host_svc_req_gen.sv
module tb_host_svc_req_gen;
    localparam int DW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_mode = 1'b0;
    logic host_ctl_we = 1'b0;
    logic [2:0] host_ctl_wdata = '0;
    logic host_dat_we = 1'b0;
    logic [DW-1:0] host_dat_wdata = '0;
    logic host_dat_re = 1'b0;
    logic [DW-1:0] host_dat_rdata;
    logic [1:0] host_status;
    logic core_pcr_we = 1'b0;
    logic [6:4] core_pcr_wdata = '0;
    logic core_dat_we = 1'b0;
    logic [DW-1:0] core_dat_wdata = '0;
    logic core_dat_re = 1'b0;
    logic [DW-1:0] core_dat_rdata;
    logic hreq_any, hreq_tx, hreq_rx, dma_rx_req, dma_tx_req;
    logic [4:0] dma_src;

    host_svc_req_gen #(.DW(DW)) dut (.*);

    always #10ns clk = ~clk;   // 50 MHz

    // Behavioural reference state
    bit m_rxen, m_txen, m_split, m_hren, m_rxdma, m_txdma, m_rxf, m_txf;
    int unsigned m_rxd, m_txd;
    bit m_any, m_tx, m_rx, m_drx, m_dtx;
    int unsigned m_src;
    int vectors = 0, fails = 0;
    bit done = 1'b0;
    bit started = 1'b0;
    string phase = "R1";

    // Advance the model at each rising edge: outputs from old state, then state.
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            {m_rxen, m_txen, m_split, m_hren, m_rxdma, m_txdma, m_rxf, m_txf} = '0;
            m_rxd = 0; m_txd = 0;
            {m_any, m_tx, m_rx, m_drx, m_dtx} = '0; m_src = 0;
        end else begin
            bit en, t, r;
            en = m_hren && !stop_mode;
            t = en && m_txen && !m_rxf;
            r = en && m_rxen && m_txf;
            m_any = !m_split && (t || r);
            m_tx = m_split && t;
            m_rx = m_split && r;
            m_drx = m_rxdma && m_rxf;
            m_dtx = m_txdma && !m_txf;
            m_src = m_drx ? 19 : (m_dtx ? 20 : 0);
            if (host_ctl_we && !stop_mode) begin
                m_rxen = host_ctl_wdata[0]; m_txen = host_ctl_wdata[1]; m_split = host_ctl_wdata[2];
            end
            if (core_pcr_we) begin
                m_hren = core_pcr_wdata[4]; m_rxdma = core_pcr_wdata[5]; m_txdma = core_pcr_wdata[6];
            end
            if (host_dat_we && !stop_mode) begin m_rxf = 1; m_rxd = host_dat_wdata; end
            else if (core_dat_re) m_rxf = 0;
            if (core_dat_we) begin m_txf = 1; m_txd = core_dat_wdata; end
            else if (host_dat_re && !stop_mode) m_txf = 0;
        end
    end

    task automatic chk(string req, string what, int unsigned act, int unsigned exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s, phase %s) at %0t: actual=%0h expected=%0h",
                     req, what, phase, $time, act, exp);
        end
    endtask

    // Compare every output on the falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            string rq;
            rq = rst_n ? "" : "R1";
            chk(rst_n ? "R6" : rq, "hreq_any", hreq_any, m_any);
            chk(rst_n ? "R7" : rq, "hreq_tx", hreq_tx, m_tx);
            chk(rst_n ? "R7" : rq, "hreq_rx", hreq_rx, m_rx);
            chk(rst_n ? "R9" : rq, "dma_rx_req", dma_rx_req, m_drx);
            chk(rst_n ? "R9" : rq, "dma_tx_req", dma_tx_req, m_dtx);
            chk(rst_n ? "R10" : rq, "dma_src", dma_src, m_src);
            chk(rst_n ? "R2" : rq, "core_dat_rdata", core_dat_rdata, m_rxd);
            chk(rst_n ? "R3" : rq, "host_dat_rdata", host_dat_rdata, m_txd);
            chk(rst_n ? "R3" : rq, "host_status", host_status, {!m_rxf, m_txf});
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
        host_ctl_we = 0; host_dat_we = 0; host_dat_re = 0;
        core_pcr_we = 0; core_dat_we = 0; core_dat_re = 0;
    endtask

    task automatic hctl_wr(logic [2:0] v);
        host_ctl_we = 1; host_ctl_wdata = v; step(1);
    endtask
    task automatic pcr_wr(logic [6:4] v);
        core_pcr_we = 1; core_pcr_wdata = v; step(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(20ns * 150000);
        fails++;
        $display("FAIL watchdog (phase %s): actual=hung expected=finished", phase);
        finish_run();
    end

    initial begin
        step(3);                                   // R1: reset state compared here
        @(negedge clk); rst_n = 1; step(2);

        phase = "R4";                              // R4 R5 R6: one-line mode
        hctl_wr(3'b011); step(2);                  // enables set, hren still 0
        pcr_wr(3'b001); step(3);                   // R5 hren on: transmit term
        phase = "R8";
        host_dat_we = 1; host_dat_wdata = 24'hA5A5A5; step(1); step(3);
        core_dat_we = 1; core_dat_wdata = 24'h123456; step(1); step(3);
        host_dat_re = 1; step(1); step(3);
        core_dat_re = 1; step(1); step(3);

        phase = "R7";                              // two-line mode
        hctl_wr(3'b111); step(2);
        core_dat_we = 1; core_dat_wdata = 24'h0F0F0F; step(1); step(2);
        host_dat_we = 1; host_dat_wdata = 24'h777777; step(1); step(2);
        hctl_wr(3'b101); step(2);
        hctl_wr(3'b110); step(2);

        phase = "R5";                              // host request enable cleared
        pcr_wr(3'b000); step(3);
        pcr_wr(3'b001); step(2);

        phase = "R11";                             // stop mode with pending data
        hctl_wr(3'b011); step(2);
        stop_mode = 1; step(2);
        host_dat_we = 1; host_dat_wdata = 24'hDEAD00; host_dat_re = 1; step(1);
        hctl_wr(3'b100); step(2);
        core_dat_re = 1; step(1);
        core_dat_we = 1; core_dat_wdata = 24'h00BEEF; step(1); step(2);
        stop_mode = 0; step(3);

        phase = "R9";                              // DMA enables and priority R10
        pcr_wr(3'b110); step(3);
        host_dat_we = 1; host_dat_wdata = 24'h111111; step(1); step(3);
        host_dat_re = 1; step(1); step(3);
        core_dat_re = 1; step(1); step(3);
        pcr_wr(3'b100); step(3);

        phase = "R2";                              // same-cycle write and read
        host_dat_we = 1; host_dat_wdata = 24'h222222; core_dat_re = 1; step(1); step(2);
        phase = "R3";
        core_dat_we = 1; core_dat_wdata = 24'h333333; host_dat_re = 1; step(1); step(2);

        phase = "mix";
        for (int i = 0; i < 2000; i++) begin
            stop_mode = ($urandom_range(0, 7) == 0);
            host_ctl_we = ($urandom_range(0, 7) == 0); host_ctl_wdata = 3'($urandom);
            core_pcr_we = ($urandom_range(0, 7) == 0); core_pcr_wdata = 3'($urandom);
            host_dat_we = $urandom_range(0, 1); host_dat_wdata = DW'($urandom);
            host_dat_re = $urandom_range(0, 1);
            core_dat_we = $urandom_range(0, 1); core_dat_wdata = DW'($urandom);
            core_dat_re = $urandom_range(0, 1);
            step(1);
        end
        stop_mode = 0; step(3);

        phase = "R1";                              // reset again from a busy state
        rst_n = 0; step(2); rst_n = 1; step(2);
        finish_run();
    end
endmodule